// File: doc/BRIEF.md
# APB Master Transfer Controller

This block sits on the bridge side of a peripheral bus and turns single read or write commands, offered on a valid/ready handshake, into APB transfers. Each accepted command walks through a one-cycle setup phase, where the decoded slave select is raised with the enable low, and then an access phase, where the enable is raised and the controller waits for the slave's ready. The read data and error flag sampled at completion come back as a one-cycle response pulse.

The target slave is picked by comparing the command address against a base/mask pair per slave. An address that matches no pair never reaches the bus and is answered with an error response. A command offered during the completing access cycle is taken at once, so the next setup phase follows without an idle cycle in between.

Top module: `apb_xfer_ctrl`

## Requirements
- R1: After reset, every select line and the enable are low, no response is valid, and the command port is ready.
- R2: In the cycle after a mapped command is accepted, exactly one select line is high and the enable is low. The bus address, direction and write data equal the command's values. Slave i is the one whose range satisfies `(addr & MASK_i) == BASE_i`. By default slave i owns addresses `i*0x1000` to `i*0x1000+0xFFF` for i = 0..3.
- R3: The cycle after the setup cycle is an access cycle: the enable is high and the same select line stays high.
- R4: While the slave's ready is low in an access cycle, the controller stays in access, and address, direction, write data, select and enable hold their values.
- R5: In the cycle after an access cycle with ready high, the response is valid for exactly one cycle. The response data is the read data sampled in that completing cycle.
- R6: The response error flag equals the slave's error input sampled in the completing access cycle. 1 means error and 0 means OKAY.
- R7: The bus direction line is 1 for a write command and 0 for a read command. A write command drives its data on the write data bus.
- R8: If no command is accepted in the completing cycle, the next cycle is idle, with all select lines and the enable low.
- R9: The command port is ready in idle cycles and in access cycles where the slave's ready is high. It is not ready in setup cycles or in waiting access cycles.
- R10: A command accepted in the completing access cycle produces a setup cycle for that command in the very next cycle, with no idle cycle between the two transfers.
- R11: A command whose address matches no slave range raises no select line and no enable. If it is accepted in idle, it is answered in the next cycle with error 1 and data 0. If it is accepted in a completing access cycle, the error response follows one cycle after that transfer's response, and the command port is not ready in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock, rising edge |
| presetn | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DATA_W | Returned read data |
| rsp_err | output | 1 | Returned error flag |
| paddr | output | ADDR_W | Bus address |
| psel | output | NSLV | One select line per slave |
| penable | output | 1 | Access phase marker |
| pwrite | output | 1 | Bus direction |
| pwdata | output | DATA_W | Bus write data |
| prdata | input | DATA_W | Read data from the selected slave, already multiplexed |
| pready | input | 1 | Slave ready, extends the access phase when low |
| pslverr | input | 1 | Slave error, valid with ready |

## Verification
The assertions assume that the shared ready, read data and error inputs come from whichever slave is selected. They also assume that these inputs carry meaning only during access cycles. The bench's slave model raises ready only while the enable is high, after a programmed number of wait cycles, and gates the error flag with that ready. Commands are driven and outputs are sampled on the falling edge, and a command is offered only while the port is ready. This keeps the command handshake free of mid-cycle changes.

// File: rtl/apb_xfer_ctrl.sv
module apb_xfer_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int NSLV   = 4,
  parameter logic [NSLV*ADDR_W-1:0] SLV_BASE = {32'h0000_3000, 32'h0000_2000, 32'h0000_1000, 32'h0000_0000},
  parameter logic [NSLV*ADDR_W-1:0] SLV_MASK = {4{32'hFFFF_F000}}
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic [ADDR_W-1:0] paddr,
  output logic [NSLV-1:0]   psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACCESS} st_t;

  st_t               state;
  logic [NSLV-1:0]   hit, sel_q;
  logic              found, err_pend, done, take, take_ok, take_bad;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_q;

  always_comb begin
    hit   = '0;
    found = 1'b0;
    for (int i = 0; i < NSLV; i++) begin
      if (!found && ((cmd_addr & SLV_MASK[i*ADDR_W +: ADDR_W]) == SLV_BASE[i*ADDR_W +: ADDR_W])) begin
        hit[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end

  assign done      = (state == ST_ACCESS) && pready;
  assign cmd_ready = !err_pend && ((state == ST_IDLE) || done);
  assign take      = cmd_valid && cmd_ready;
  assign take_ok   = take && found;
  assign take_bad  = take && !found;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      state     <= ST_IDLE;
      sel_q     <= '0;
      addr_q    <= '0;
      wd_q      <= '0;
      wr_q      <= 1'b0;
      err_pend  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      if (take_ok) begin
        sel_q  <= hit;
        addr_q <= cmd_addr;
        wd_q   <= cmd_wdata;
        wr_q   <= cmd_write;
      end
      case (state)
        ST_IDLE:   if (take_ok) state <= ST_SETUP;
        ST_SETUP:  state <= ST_ACCESS;
        ST_ACCESS: if (pready) state <= take_ok ? ST_SETUP : ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
      rsp_valid <= 1'b0;
      if (done) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= prdata;
        rsp_err   <= pslverr;
      end else if (err_pend || take_bad) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
        rsp_err   <= 1'b1;
      end
      err_pend <= done && take_bad;
    end
  end

  assign psel    = (state == ST_IDLE) ? '0 : sel_q;
  assign penable = (state == ST_ACCESS);
  assign paddr   = addr_q;
  assign pwrite  = wr_q;
  assign pwdata  = wd_q;

  a_r2_single_select: assert property (@(posedge pclk) disable iff (!presetn)
    $onehot0(psel));

  a_r3_setup_then_access: assert property (@(posedge pclk) disable iff (!presetn)
    (psel != '0 && !penable) |=> (penable && $stable(psel)));

  a_r3_enable_needs_select: assert property (@(posedge pclk) disable iff (!presetn)
    penable |-> (psel != '0));

  a_r4_hold_in_wait: assert property (@(posedge pclk) disable iff (!presetn)
    (penable && !pready) |=> (penable && $stable(psel) && $stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  a_r5_response_after_done: assert property (@(posedge pclk) disable iff (!presetn)
    (penable && pready) |=> (rsp_valid && rsp_rdata == $past(prdata) && rsp_err == $past(pslverr)));

  a_r9_no_take_while_waiting: assert property (@(posedge pclk) disable iff (!presetn)
    (penable && !pready) |-> !cmd_ready);

  a_r9_no_take_in_setup: assert property (@(posedge pclk) disable iff (!presetn)
    (psel != '0 && !penable) |-> !cmd_ready);

endmodule

// File: tb/apb_xfer_ctrl_tb.sv
module apb_xfer_ctrl_tb;
  logic        pclk = 1'b0, presetn = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0, cmd_wdata = '0;
  logic        cmd_ready, rsp_valid, rsp_err, penable, pwrite;
  logic [31:0] rsp_rdata, paddr, pwdata, prdata;
  logic [3:0]  psel;
  logic        pready, pslverr;

  int waits = 0, acc_cnt = 0;
  logic [31:0] rd_val = '0;
  logic        err_val = 1'b0;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #2 pclk = ~pclk;

  assign pready  = penable && (acc_cnt == waits);
  assign prdata  = rd_val;
  assign pslverr = err_val && pready;

  always @(posedge pclk) acc_cnt <= (penable && !pready) ? acc_cnt + 1 : 0;

  apb_xfer_ctrl u_dut (
    .pclk(pclk), .presetn(presetn),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .paddr(paddr), .psel(psel), .penable(penable), .pwrite(pwrite), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic offer(logic wr, logic [31:0] a, logic [31:0] d);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
  endtask

  task automatic t_reset;
    chk("R1 psel", psel, 0);
    chk("R1 penable", penable, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 cmd_ready", cmd_ready, 1);
  endtask

  task automatic t_single(logic wr, logic [31:0] a, logic [31:0] d, int nw,
                          logic [31:0] rv, logic ev, logic [3:0] exp_sel);
    waits = nw; rd_val = rv; err_val = ev;
    offer(wr, a, d);
    chk("R9 ready idle", cmd_ready, 1);
    @(negedge pclk); cmd_valid = 1'b0;
    chk("R2 sel", psel, exp_sel);
    chk("R2 enable low", penable, 0);
    chk("R2 addr", paddr, a);
    chk("R7 dir", pwrite, wr);
    if (wr) chk("R7 wdata", pwdata, d);
    chk("R9 not ready setup", cmd_ready, 0);
    @(negedge pclk);
    chk("R3 enable", penable, 1);
    chk("R3 sel", psel, exp_sel);
    for (int k = 0; k < nw; k++) begin
      chk("R9 not ready wait", cmd_ready, 0);
      @(negedge pclk);
      chk("R4 enable held", penable, 1);
      chk("R4 addr held", paddr, a);
      chk("R4 sel held", psel, exp_sel);
      chk("R4 dir held", pwrite, wr);
      chk("R5 no early rsp", rsp_valid, 0);
    end
    chk("R9 ready done", cmd_ready, 1);
    @(negedge pclk);
    chk("R5 rsp valid", rsp_valid, 1);
    if (!wr) chk("R5 rdata", rsp_rdata, rv);
    chk("R6 err", rsp_err, ev);
    chk("R8 idle sel", psel, 0);
    chk("R8 idle en", penable, 0);
    @(negedge pclk);
    chk("R5 pulse ends", rsp_valid, 0);
  endtask

  task automatic t_back2back;
    waits = 0; err_val = 1'b0; rd_val = 32'h1111_2222;
    offer(1'b0, 32'h0000_0010, 0);
    @(negedge pclk); cmd_valid = 1'b0;
    @(negedge pclk);
    chk("R10 ready at done", cmd_ready, 1);
    offer(1'b1, 32'h0000_3ABC, 32'hCAFE_0003);
    @(negedge pclk); cmd_valid = 1'b0;
    chk("R10 first rsp", rsp_valid, 1);
    chk("R10 first rdata", rsp_rdata, 32'h1111_2222);
    chk("R10 setup no idle sel", psel, 4'b1000);
    chk("R10 setup no idle en", penable, 0);
    chk("R10 new addr", paddr, 32'h0000_3ABC);
    chk("R7 new wdata", pwdata, 32'hCAFE_0003);
    @(negedge pclk);
    chk("R10 second access", penable, 1);
    @(negedge pclk);
    chk("R10 second rsp", rsp_valid, 1);
    chk("R8 idle after", psel, 0);
    @(negedge pclk);
  endtask

  task automatic t_unmapped_idle;
    offer(1'b0, 32'h0001_0000, 0);
    @(negedge pclk); cmd_valid = 1'b0;
    chk("R11 no sel", psel, 0);
    chk("R11 no en", penable, 0);
    chk("R11 rsp", rsp_valid, 1);
    chk("R11 err", rsp_err, 1);
    chk("R11 data zero", rsp_rdata, 0);
    @(negedge pclk);
    chk("R11 pulse ends", rsp_valid, 0);
  endtask

  task automatic t_unmapped_chained;
    waits = 0; err_val = 1'b0; rd_val = 32'h5A5A_0001;
    offer(1'b0, 32'h0000_2004, 0);
    @(negedge pclk); cmd_valid = 1'b0;
    @(negedge pclk);
    offer(1'b1, 32'h8000_0000, 32'h1);
    @(negedge pclk); cmd_valid = 1'b0;
    chk("R11 apb rsp first", rsp_valid, 1);
    chk("R11 apb rsp ok", rsp_err, 0);
    chk("R11 apb rdata", rsp_rdata, 32'h5A5A_0001);
    chk("R11 no sel", psel, 0);
    chk("R11 not ready", cmd_ready, 0);
    @(negedge pclk);
    chk("R11 err rsp", rsp_valid, 1);
    chk("R11 err flag", rsp_err, 1);
    chk("R11 no en", penable, 0);
    @(negedge pclk);
    chk("R11 done", rsp_valid, 0);
    chk("R1 ready again", cmd_ready, 1);
  endtask

  initial begin
    #4000;
    if (!finished) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge pclk);
    t_reset;
    presetn = 1'b1;
    @(negedge pclk);
    t_reset;
    t_single(1'b0, 32'h0000_0004, 0, 0, 32'hDEAD_BEEF, 1'b0, 4'b0001);
    t_single(1'b1, 32'h0000_1FFC, 32'h0BAD_F00D, 0, 0, 1'b0, 4'b0010);
    t_single(1'b0, 32'h0000_2100, 0, 3, 32'h1234_5678, 1'b0, 4'b0100);
    t_single(1'b1, 32'h0000_3008, 32'hA5A5_5A5A, 2, 0, 1'b1, 4'b1000);
    t_single(1'b0, 32'h0000_0FF0, 0, 1, 32'h0000_00FF, 1'b1, 4'b0001);
    t_back2back;
    t_unmapped_idle;
    t_unmapped_chained;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule